// File: doc/BRIEF.md
# Vectored Interrupt Controller with Context Shadow

This block collects event strobes from nine peripheral sources into pending flags. Each flag has its own mask bit, and one global enable gates all of them. When the core reports an instruction boundary and the global enable is set, the controller picks the highest-priority pending source that is enabled. In that same cycle it raises a take strobe and presents a fixed vector address for the fetch unit. A flag records its event whether or not interrupts are enabled. Reading the flag register returns the flags ANDed with the mask. Only software clears a flag.

When an interrupt is taken, the accumulator and two core registers are copied into a single shadow set. The core reloads its registers from the shadow outputs when it executes the return instruction. There is only one shadow set, so a later entry overwrites the saved values with the values current at that moment. The enable, disable and return instruction strobes drive the global enable.

Top module: `vic_top`

## Requirements
- R1: A high bit on `irq_req` sets the matching flag at the next clock edge, whether or not the global enable is set. A request and a clear of the same bit in the same cycle leave the flag set.
- R2: A flag is cleared only by a 1 in the matching bit of `flag_clr`. It stays set through entry, service and return until software clears it.
- R3: `flag_rd` always equals the flags ANDed with the mask. The mask is loaded from `mask_data` on a cycle with `mask_wr` high, and a mask bit of 1 enables its source.
- R4: After reset the flags, the mask and the global enable are all 0. As a result `flag_rd` is 0 and `take` is 0.
- R5: `op_eni` and `op_reti` set the global enable, and `op_disi` clears it. `op_disi` wins over `op_eni` or `op_reti` in the same cycle.
- R6: `take` is high in the same cycle exactly when the global enable, `instr_boundary` and at least one enabled flag are all true. The global enable reads 0 in the cycle after a take, even if `op_eni` arrived with the take.
- R7: Bit index to source and vector: 0 external pin 0x003, 1 main timer 0x009, 2 converter done 0x00C, 3 comparator 0x00F, 4 high-time underflow 0x012, 5 low-time underflow 0x015, 6 timer A 0x018, 7 timer B 0x01B, 8 timer C 0x01E. When several sources are enabled and pending, the lowest vector is chosen.
- R8: On a take, `acc_live`, `stat_live` and `sel_live` are captured. From the next cycle onward `rest_acc`, `rest_stat` and `rest_sel` show the captured values. The shadow resets to 0.
- R9: Each later take overwrites the single shadow set, including a nested take during service.
- R10: After `op_reti`, a flag that is still set and enabled causes another take at the next instruction boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 9 | Event strobes, one per source |
| instr_boundary | input | 1 | The core can accept an interrupt this cycle |
| op_eni | input | 1 | Enable-interrupt instruction strobe |
| op_disi | input | 1 | Disable-interrupt instruction strobe |
| op_reti | input | 1 | Return-from-interrupt instruction strobe |
| flag_clr | input | 9 | Software clear, one bit per flag |
| mask_wr | input | 1 | Mask register write strobe |
| mask_data | input | 9 | New mask value |
| acc_live | input | 8 | Current accumulator |
| stat_live | input | 8 | Current first saved core register |
| sel_live | input | 8 | Current second saved core register |
| take | output | 1 | Interrupt taken this cycle |
| vec_addr | output | 10 | Vector of the selected source |
| rest_acc | output | 8 | Shadowed accumulator |
| rest_stat | output | 8 | Shadowed first core register |
| rest_sel | output | 8 | Shadowed second core register |
| flag_rd | output | 9 | Flags ANDed with the mask |

## Verification
The bound checker checks properties that hold on every cycle:
- a take only ever happens with the enable set, at a boundary and with a nonzero masked flag value;
- the enable drops after a take and follows the instruction strobes;
- every request lands in its flag;
- each vector is one of the legal slots;
- the shadow accumulator holds the value it had at the take.

Priority order, the exact vector for each source, the retake after return and the overwrite of the shadow by a nested entry depend on particular event orderings. Only the bench's directed sequences and its reference model, compared on every clock, can show them.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC   = 9;
  localparam int VEC_W  = 10;
  localparam int DATA_W = 8;

  typedef enum logic [3:0] {
    SRC_PIN  = 4'd0,
    SRC_TMR0 = 4'd1,
    SRC_ADC  = 4'd2,
    SRC_CMP  = 4'd3,
    SRC_HI   = 4'd4,
    SRC_LO   = 4'd5,
    SRC_TMRA = 4'd6,
    SRC_TMRB = 4'd7,
    SRC_TMRC = 4'd8
  } src_e;

  // Slot 0 sits at 3; every later slot k sits at 6 + 3k.
  function automatic logic [VEC_W-1:0] vec_of(input int unsigned idx);
    if (idx == 0) return VEC_W'(3);
    return VEC_W'(6 + 3 * idx);
  endfunction
endpackage

// File: rtl/vic_flags.sv
module vic_flags #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    for (int i = 0; i < N; i++) begin
      if (set_i[i])      flags_d[i] = 1'b1;
      else if (clr_i[i]) flags_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int N     = 9,
  parameter int VEC_W = 10
) (
  input  logic [N-1:0]     pend_i,
  output logic             any_o,
  output logic [VEC_W-1:0] vec_o
);
  import vic_pkg::*;

  always_comb begin
    any_o = |pend_i;
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_o = vec_of(i);
    end
  end
endmodule

// File: rtl/vic_shadow.sv
module vic_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] sel_o
);
  logic [W-1:0] acc_q, stat_q, sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      stat_q <= '0;
      sel_q  <= '0;
    end else if (cap_i) begin
      acc_q  <= acc_i;
      stat_q <= stat_i;
      sel_q  <= sel_i;
    end
  end

  assign acc_o  = acc_q;
  assign stat_o = stat_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/vic_top.sv
module vic_top #(
  parameter int NSRC   = vic_pkg::NSRC,
  parameter int VEC_W  = vic_pkg::VEC_W,
  parameter int DATA_W = vic_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_req,
  input  logic              instr_boundary,
  input  logic              op_eni,
  input  logic              op_disi,
  input  logic              op_reti,
  input  logic [NSRC-1:0]   flag_clr,
  input  logic              mask_wr,
  input  logic [NSRC-1:0]   mask_data,
  input  logic [DATA_W-1:0] acc_live,
  input  logic [DATA_W-1:0] stat_live,
  input  logic [DATA_W-1:0] sel_live,
  output logic              take,
  output logic [VEC_W-1:0]  vec_addr,
  output logic [DATA_W-1:0] rest_acc,
  output logic [DATA_W-1:0] rest_stat,
  output logic [DATA_W-1:0] rest_sel,
  output logic [NSRC-1:0]   flag_rd
);
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] pend;
  logic            gie_q, gie_d;
  logic            any_pend;

  vic_flags #(.N(NSRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (irq_req),
    .clr_i  (flag_clr),
    .flags_o(flag_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_data;
  end

  assign pend    = flag_q & mask_q;
  assign flag_rd = pend;

  vic_arbiter #(.N(NSRC), .VEC_W(VEC_W)) u_arb (
    .pend_i(pend),
    .any_o (any_pend),
    .vec_o (vec_addr)
  );

  assign take = gie_q & instr_boundary & any_pend;

  always_comb begin
    gie_d = gie_q;
    if (take)                   gie_d = 1'b0;
    else if (op_disi)           gie_d = 1'b0;
    else if (op_eni || op_reti) gie_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else        gie_q <= gie_d;
  end

  vic_shadow #(.W(DATA_W)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_i (take),
    .acc_i (acc_live),
    .stat_i(stat_live),
    .sel_i (sel_live),
    .acc_o (rest_acc),
    .stat_o(rest_stat),
    .sel_o (rest_sel)
  );
endmodule

// File: rtl/vic_top_chk.sv
module vic_top_chk #(
  parameter int NSRC   = 9,
  parameter int VEC_W  = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   irq_req,
  input logic              instr_boundary,
  input logic              op_eni,
  input logic              op_disi,
  input logic              op_reti,
  input logic [DATA_W-1:0] acc_live,
  input logic              take,
  input logic [VEC_W-1:0]  vec_addr,
  input logic [DATA_W-1:0] rest_acc,
  input logic [NSRC-1:0]   flag_rd,
  input logic [NSRC-1:0]   flag_q,
  input logic              gie_q
);
  // R1
  req_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_req) |=> ((flag_q & $past(irq_req)) == $past(irq_req)));

  // R6
  take_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (gie_q && instr_boundary && (flag_rd != '0)));

  // R6
  take_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie_q);

  // R5
  disi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_disi |=> !gie_q);

  // R5
  eni_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_eni || op_reti) && !op_disi && !take) |=> gie_q);

  // R7
  vec_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (vec_addr >= VEC_W'(3) && vec_addr <= VEC_W'(30) && (vec_addr % 3) == 0));

  // R8
  shadow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (rest_acc == $past(acc_live)));
endmodule

bind vic_top vic_top_chk #(.NSRC(NSRC), .VEC_W(VEC_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .irq_req       (irq_req),
  .instr_boundary(instr_boundary),
  .op_eni        (op_eni),
  .op_disi       (op_disi),
  .op_reti       (op_reti),
  .acc_live      (acc_live),
  .take          (take),
  .vec_addr      (vec_addr),
  .rest_acc      (rest_acc),
  .flag_rd       (flag_rd),
  .flag_q        (flag_q),
  .gie_q         (gie_q)
);

// File: tb/vic_top_test.sv
module vic_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] irq_req, flag_clr, mask_data;
  logic       instr_boundary, op_eni, op_disi, op_reti, mask_wr;
  logic [7:0] acc_live, stat_live, sel_live;
  logic       take;
  logic [9:0] vec_addr;
  logic [7:0] rest_acc, rest_stat, rest_sel;
  logic [8:0] flag_rd;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit m_flag[9];
  bit m_mask[9];
  bit m_gie;
  int m_acc, m_stat, m_sel;
  int vec_tab[9] = '{3, 9, 12, 15, 18, 21, 24, 27, 30};

  always #10 clk = ~clk;

  vic_top uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_boundary(instr_boundary),
    .op_eni(op_eni), .op_disi(op_disi), .op_reti(op_reti), .flag_clr(flag_clr),
    .mask_wr(mask_wr), .mask_data(mask_data), .acc_live(acc_live),
    .stat_live(stat_live), .sel_live(sel_live), .take(take), .vec_addr(vec_addr),
    .rest_acc(rest_acc), .rest_stat(rest_stat), .rest_sel(rest_sel), .flag_rd(flag_rd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rd();
    int v = 0;
    for (int i = 0; i < 9; i++) if (m_flag[i] && m_mask[i]) v |= (1 << i);
    return v;
  endfunction

  function automatic int exp_vec();
    for (int i = 0; i < 9; i++) if (m_flag[i] && m_mask[i]) return vec_tab[i];
    return -1;
  endfunction

  task automatic idle();
    irq_req = '0; flag_clr = '0; mask_wr = 1'b0; mask_data = '0;
    instr_boundary = 1'b0; op_eni = 1'b0; op_disi = 1'b0; op_reti = 1'b0;
  endtask

  // compare and advance the model; inputs must already be applied
  task automatic tick();
    int  rd;
    bit  tk;
    @(negedge clk);
    #4;
    rd = exp_rd();
    tk = m_gie && instr_boundary && (rd != 0);
    chk("R3 flag_rd", int'(flag_rd), rd);
    chk("R6 take", int'(take), int'(tk));
    if (tk) chk("R7 vec_addr", int'(vec_addr), exp_vec());
    chk("R8 rest_acc", int'(rest_acc), m_acc);
    chk("R8 rest_stat", int'(rest_stat), m_stat);
    chk("R9 rest_sel", int'(rest_sel), m_sel);
    if (rst_n) begin
      for (int i = 0; i < 9; i++) begin
        if (irq_req[i]) m_flag[i] = 1'b1;
        else if (flag_clr[i]) m_flag[i] = 1'b0;
        if (mask_wr) m_mask[i] = mask_data[i];
      end
      if (tk) begin
        m_acc = acc_live; m_stat = stat_live; m_sel = sel_live;
      end
      if (tk || op_disi) m_gie = 1'b0;
      else if (op_eni || op_reti) m_gie = 1'b1;
    end
    @(posedge clk);
    #1;
    idle();
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    acc_live = 8'h11; stat_live = 8'h22; sel_live = 8'h33;
    m_gie = 0; m_acc = 0; m_stat = 0; m_sel = 0;
    for (int i = 0; i < 9; i++) begin m_flag[i] = 0; m_mask[i] = 0; end
    irq_req = 9'h1FF;        // R4: requests are held off during reset
    tick();
    idle(); tick();
    chk("R4 reset flag_rd", int'(flag_rd), 0);
    chk("R4 reset take", int'(take), 0);
    @(negedge clk); rst_n = 1'b1; @(posedge clk); #1;

    // R1: flags latch while disabled; masked reads stay 0
    irq_req = 9'b100100010; tick();
    tick();
    // R3: open the mask and read back
    mask_wr = 1'b1; mask_data = 9'h1FF; tick();
    chk("R1 flags latched while disabled", int'(flag_rd), 9'b100100010);
    // R1: clear and set of the same bit in one cycle keeps it set
    flag_clr = 9'b100000010; irq_req = 9'b000000010; tick();
    chk("R1 set beats clear", int'(flag_rd), 9'b000100010);
    // R2: clear remaining flags
    flag_clr = 9'h1FF; tick();
    chk("R2 clear", int'(flag_rd), 0);

    // R7: priority, lowest vector wins
    irq_req = 9'b101010000; tick();
    op_eni = 1'b1; tick();
    acc_live = 8'hA1; stat_live = 8'hA2; sel_live = 8'hA3;
    instr_boundary = 1'b1; tick();
    chk("R8 shadow acc", int'(rest_acc), 8'hA1);
    // R6: enable dropped, no new take at a boundary
    instr_boundary = 1'b1; tick();
    // R10: return with flag still set takes it again
    op_reti = 1'b1; tick();
    acc_live = 8'hB1; instr_boundary = 1'b1; tick();
    // R2: clear bit 4, return, next source wins
    flag_clr = 9'b000010000; op_reti = 1'b1; tick();
    instr_boundary = 1'b1; tick();
    // R9: nested entry overwrites shadow
    op_eni = 1'b1; irq_req = 9'b000000001; tick();
    acc_live = 8'hC7; stat_live = 8'hC8; sel_live = 8'hC9; instr_boundary = 1'b1; tick();
    chk("R9 nested overwrite", int'(rest_sel), 8'hC9);
    // R5: disable beats enable in the same cycle
    flag_clr = 9'h1FF; op_eni = 1'b1; op_disi = 1'b1; tick();
    irq_req = 9'b000000100; tick();
    instr_boundary = 1'b1; tick();
    chk("R5 disi wins", int'(take), 0);
    // R6: take beats enable in same cycle
    op_reti = 1'b1; tick();
    instr_boundary = 1'b1; op_eni = 1'b1; tick();
    instr_boundary = 1'b1; tick();
    // R3: partial mask hides a pending flag
    mask_wr = 1'b1; mask_data = 9'b000000011; tick();
    chk("R3 masked read", int'(flag_rd), 0);

    // mixed phase
    for (int n = 0; n < 4000; n++) begin
      irq_req        = (($urandom % 6) == 0) ? 9'($urandom) : '0;
      flag_clr       = (($urandom % 4) == 0) ? 9'($urandom) : '0;
      mask_wr        = (($urandom % 25) == 0);
      mask_data      = 9'($urandom);
      instr_boundary = (($urandom % 3) != 0);
      op_eni         = (($urandom % 9) == 0);
      op_disi        = (($urandom % 17) == 0);
      op_reti        = (($urandom % 11) == 0);
      acc_live = 8'($urandom); stat_live = 8'($urandom); sel_live = 8'($urandom);
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule